// File: doc/BRIEF.md
# Modular Ring Butterfly

This block is the radix-2 butterfly of a number-theoretic transform, which is a Fourier-style transform whose arithmetic works on integers modulo an odd prime q and not on complex numbers. Each accepted input carries two coefficients A and B, both already reduced into [0, q-1], and one twiddle factor. The twiddle is a modular root of unity W, and it arrives in Montgomery form, which is W·2^WIDTH mod q. The block multiplies B by the twiddle with a Montgomery product. That product gives the plain value W·B mod q, so the result is out of the Montgomery domain. The block then returns the modular sum and the modular difference of A and that product.

The datapath is pipelined over a fixed number of register stages, so that no stage holds a full wide multiply and a reduction in series. A valid flag moves along with the data and marks which output cycles carry results. A new operand set can enter on every clock cycle. The caller supplies the twiddles and orders the data. The caller must also keep q odd, with 2 < q < 2^WIDTH.

Top module: `modq_butterfly`

## Requirements
- R1: When out_valid is high, out_x equals (A + W·B) mod q. Here A and B are the coefficients accepted with the matching in_valid, and W is the plain twiddle whose Montgomery form (W·2^WIDTH mod q) was driven on in_tw.
- R2: When out_valid is high, out_y equals (A − W·B) mod q. When the raw difference is negative, the block adds q to it.
- R3: For inputs in [0, q-1], the internal Montgomery product and both outputs always lie in [0, q-1].
- R4: The latency is exactly 4 cycles. out_valid in any cycle equals in_valid sampled 4 clock edges earlier.
- R5: While rst is high, and in the cycle after the last reset edge, out_valid, out_x and out_y are all 0. This holds whatever in_valid does during reset.
- R6: While out_valid is low, out_x and out_y keep the last values they held.
- R7: The block accepts a new operand set on every cycle. Back-to-back inputs produce back-to-back results in the same order.
- R8: A twiddle input equal to 2^WIDTH mod q (that is, W = 1) yields out_x = (A + B) mod q and out_y = (A − B) mod q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set on in_a, in_b, in_tw is valid |
| in_a | input | WIDTH | First coefficient, in [0, q-1] |
| in_b | input | WIDTH | Second coefficient, in [0, q-1] |
| in_tw | input | WIDTH | Twiddle in Montgomery form, in [0, q-1] |
| out_valid | output | 1 | Result on out_x and out_y is valid |
| out_x | output | WIDTH | Modular sum output |
| out_y | output | WIDTH | Modular difference output |

## Verification
The bench builds the block with WIDTH = 5 and q = 29. That modulus sits close to 2^5, so the conditional subtraction after the Montgomery reduction is taken often, and so is the add-back of q in the difference. With a field that small, every combination of A, B and plain twiddle W is driven: 29^3 operand sets. This covers W = 0, W = 1, A = 0, B = 0 and all the wrap cases. Idle cycles are placed among the stream at a regular pattern, so the hold behaviour and the valid timing are checked against a four-deep model of the expected results. Streaming runs in between exercise back-to-back operation.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

    // Fixed pipeline depth from input registers to output registers.
    localparam int LATENCY = 4;

    // Returns -q^-1 mod 2^64 for an odd q, by Newton iteration on the inverse.
    function automatic logic [63:0] neg_inv_pow2(input logic [63:0] q);
        logic [63:0] x;
        x = q;
        for (int i = 0; i < 6; i++) begin
            x = x * (64'd2 - q * x);
        end
        return (~x) + 64'd1;
    endfunction

endpackage

// File: rtl/mrb_montmul.sv
module mrb_montmul #(
    parameter int WIDTH = 16,
    parameter int Q     = 12289
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_tw,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_a,
    output logic [WIDTH-1:0] out_p
);
    localparam int DW = 2 * WIDTH;
    localparam logic [WIDTH-1:0] QINV   = WIDTH'(mrb_pkg::neg_inv_pow2(64'(Q)));
    localparam logic [WIDTH:0]   Q_EXT  = (WIDTH+1)'(Q);
    localparam logic [DW:0]      Q_WIDE = (DW+1)'(Q);

    typedef struct packed {
        logic             v;
        logic [WIDTH-1:0] a;
        logic [DW-1:0]    t;
    } mul_stage_t;

    typedef struct packed {
        logic             v;
        logic [WIDTH-1:0] a;
        logic [DW-1:0]    t;
        logic [WIDTH-1:0] m;
    } red_stage_t;

    typedef struct packed {
        logic             v;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] p;
    } prod_stage_t;

    mul_stage_t  s1;
    red_stage_t  s2;
    prod_stage_t s3;

    // Stage 1: full-width product of twiddle and coefficient.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.v <= in_valid;
            if (in_valid) begin
                s1.a <= in_a;
                s1.t <= DW'(in_tw) * DW'(in_b);
            end
        end
    end

    // Stage 2: Montgomery quotient digit from the low half of the product.
    logic [DW-1:0] m_full;
    always_comb m_full = DW'(s1.t[WIDTH-1:0]) * DW'(QINV);

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.v <= s1.v;
            if (s1.v) begin
                s2.a <= s1.a;
                s2.t <= s1.t;
                s2.m <= m_full[WIDTH-1:0];
            end
        end
    end

    // Stage 3: add m*q, shift down by WIDTH, one conditional subtraction.
    logic [DW:0]    red_sum;
    logic [WIDTH:0] red_hi;
    logic [WIDTH:0] red_fix;
    always_comb begin
        red_sum = (DW+1)'(s2.t) + (DW+1)'(s2.m) * Q_WIDE;
        red_hi  = red_sum[DW:WIDTH];
        red_fix = (red_hi >= Q_EXT) ? (red_hi - Q_EXT) : red_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s3 <= '0;
        end else begin
            s3.v <= s2.v;
            if (s2.v) begin
                s3.a <= s2.a;
                s3.p <= red_fix[WIDTH-1:0];
            end
        end
    end

    assign out_valid = s3.v;
    assign out_a     = s3.a;
    assign out_p     = s3.p;

    assert_prod_below_q_R3: assert property (@(posedge clk) disable iff (rst)
        s3.v |-> ((WIDTH+1)'(s3.p) < Q_EXT));

endmodule

// File: rtl/mrb_addsub.sv
module mrb_addsub #(
    parameter int WIDTH = 16,
    parameter int Q     = 12289
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_p,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_x,
    output logic [WIDTH-1:0] out_y
);
    localparam logic [WIDTH:0] Q_EXT = (WIDTH+1)'(Q);

    logic [WIDTH:0] a_ext, p_ext, sum_raw, sum_fix, dif_fix;
    always_comb begin
        a_ext   = {1'b0, in_a};
        p_ext   = {1'b0, in_p};
        sum_raw = a_ext + p_ext;
        sum_fix = (sum_raw >= Q_EXT) ? (sum_raw - Q_EXT) : sum_raw;
        dif_fix = (a_ext >= p_ext) ? (a_ext - p_ext) : (a_ext + Q_EXT - p_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_x <= sum_fix[WIDTH-1:0];
                out_y <= dif_fix[WIDTH-1:0];
            end
        end
    end

    assert_out_below_q_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((WIDTH+1)'(out_x) < Q_EXT) && ((WIDTH+1)'(out_y) < Q_EXT)));

endmodule

// File: rtl/modq_butterfly.sv
module modq_butterfly #(
    parameter int WIDTH = 16,
    parameter int Q     = 12289
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_tw,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_x,
    output logic [WIDTH-1:0] out_y
);
    logic             mm_valid;
    logic [WIDTH-1:0] mm_a;
    logic [WIDTH-1:0] mm_p;

    mrb_montmul #(.WIDTH(WIDTH), .Q(Q)) mul_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_a     (in_a),
        .in_b     (in_b),
        .in_tw    (in_tw),
        .out_valid(mm_valid),
        .out_a    (mm_a),
        .out_p    (mm_p)
    );

    mrb_addsub #(.WIDTH(WIDTH), .Q(Q)) as_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mm_valid),
        .in_a     (mm_a),
        .in_p     (mm_p),
        .out_valid(out_valid),
        .out_x    (out_x),
        .out_y    (out_y)
    );

    // Cycles since reset release, saturating, so the latency check never reaches into reset.
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'(mrb_pkg::LATENCY)) |-> (out_valid == $past(in_valid, 4)));

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_x) && $stable(out_y)));

endmodule

// File: tb/modq_butterfly_tb_top.sv
module modq_butterfly_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 5;
    localparam int Q          = 29;
    localparam int RMOD       = (1 << WIDTH) % Q;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [WIDTH-1:0] in_a = '0, in_b = '0, in_tw = '0;
    logic             out_valid;
    logic [WIDTH-1:0] out_x, out_y;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Expected-result model, four deep, index 3 is the one due now.
    bit exp_v [4];
    int exp_x [4];
    int exp_y [4];
    int last_x = 0;
    int last_y = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modq_butterfly #(.WIDTH(WIDTH), .Q(Q)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_tw(in_tw),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
    );

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: check what is due, advance the model, drive the next operands.
    task automatic step(input bit v, input int a, input int b, input int w);
        @(negedge clk);
        check_int("R4 out_valid", int'(out_valid), int'(exp_v[3]));
        if (exp_v[3]) begin
            check_int("R1 out_x", int'(out_x), exp_x[3]);
            check_int("R2 out_y", int'(out_y), exp_y[3]);
            last_x = exp_x[3];
            last_y = exp_y[3];
        end else begin
            check_int("R6 hold out_x", int'(out_x), last_x);
            check_int("R6 hold out_y", int'(out_y), last_y);
        end
        for (int i = 3; i > 0; i--) begin
            exp_v[i] = exp_v[i-1];
            exp_x[i] = exp_x[i-1];
            exp_y[i] = exp_y[i-1];
        end
        exp_v[0] = v;
        if (v) begin
            int wb;
            wb = (w * b) % Q;
            exp_x[0] = (a + wb) % Q;
            exp_y[0] = (a - wb + Q) % Q;
        end
        in_valid = v;
        in_a     = WIDTH'(a);
        in_b     = WIDTH'(b);
        in_tw    = WIDTH'((w * RMOD) % Q);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            exp_v[i] = 1'b0; exp_x[i] = 0; exp_y[i] = 0;
        end
        // Reset with in_valid held high: it must leave no trace (R5).
        in_valid = 1'b1; in_a = 5'd7; in_b = 5'd9; in_tw = 5'd3;
        repeat (3) @(negedge clk);
        check_int("R5 reset out_valid", int'(out_valid), 0);
        check_int("R5 reset out_x", int'(out_x), 0);
        check_int("R5 reset out_y", int'(out_y), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        // R8: twiddle 2^WIDTH mod q (W = 1) gives plain sum and difference.
        step(1'b1, 3, 10, 1);
        step(1'b1, 0, 28, 1);
        step(1'b1, 28, 28, 1);
        // Exhaustive sweep, idle gaps at a fixed pattern (R1, R2, R3, R6, R7).
        for (int a = 0; a < Q; a++) begin
            for (int b = 0; b < Q; b++) begin
                for (int w = 0; w < Q; w++) begin
                    if (((a + 2 * b + 3 * w) % 11) == 0) step(1'b0, 0, 0, 0);
                    step(1'b1, a, b, w);
                end
            end
        end
        for (int i = 0; i < 6; i++) step(1'b0, 0, 0, 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule